// File: doc/BRIEF.md
# Pipelined Integer Multiply Unit

This unit is the multiply execution pipe of a 64-bit integer core. Each cycle it can take one operation: two register operands, a three-bit operation code, a record flag, an overflow-enable flag, the current summary-overflow bit and a small transaction tag. Three cycles later it returns the product word. Alongside the product it returns the overflow bits (a 64-bit and a 32-bit flag), the updated summary-overflow bit, and write qualifiers telling the core which of these to commit. When the record flag is set it also returns a four-bit condition field for condition field 0.

The supported forms are:
- the signed 32x32 product returned in full;
- the upper half of a 32x32 product, signed or unsigned;
- the low 64 bits of a signed 64x64 product;
- the upper 64 bits of a 64x64 product, signed or unsigned;
- an immediate form that takes a signed 16-bit constant as its second factor.

A valid/ready pair at each end moves work through the pipe. If downstream ready drops while a result is waiting, the whole pipe freezes. Downstream ready may also be tied high, and the unit then runs at one operation per cycle.

Top module: `mul_pipe_unit`

## Requirements
- R1: Operation code 0 multiplies the signed low 32 bits of both operands and returns the full signed 64-bit product. Both overflow flags are 1 when that product lies outside the signed 32-bit range.
- R2: Operation codes 1 (signed) and 2 (unsigned) form the 64-bit product of the low 32 bits of both operands. Bits 63:32 of that product go to result bits 31:0, and the same value is copied into bits 63:32. Both overflow flags are 0.
- R3: Operation code 3 returns the low 64 bits of the signed 128-bit product. Both overflow flags are 1 when the product lies outside the signed 64-bit range.
- R4: Operation codes 4 (signed) and 5 (unsigned) return bits 127:64 of the 128-bit product of the two full operands. Both overflow flags are 0.
- R5: Operation code 6 uses operand B bits 15:0, sign-extended, as the second factor and ignores B bits 63:16. Result and overflow then follow R3.
- R6: Both the overflow and the summary-overflow write qualifiers equal the operation's overflow-enable bit. With the bit clear, both qualifiers are 0.
- R7: The summary-overflow output equals the incoming summary bit ORed with the new overflow, and the overflow term counts only when overflow-enable is set.
- R8: The condition qualifier equals the record bit. The condition field is {LT, GT, EQ, SO} in bits 3..0: a signed compare of result bits 31:0 with zero for codes 0 to 2, of the full result with zero otherwise, and SO equal to the summary-overflow output.
- R9: A result appears exactly three cycles after its operation is accepted, with an idle pipe and ready high. A new operation can be accepted every cycle, results come out in order, and each carries its transaction tag. After reset, valid out is 0 and ready out is 1.
- R10: Ready out equals (not valid out) OR ready in. While valid out is high and ready in is low, the pipe holds, and valid out and the result stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present |
| ready_o | output | 1 | Unit can accept an operation |
| op_i | input | 3 | Operation code (see R1 to R5) |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand or immediate in bits 15:0 |
| rc_i | input | 1 | Record: produce condition field |
| oe_i | input | 1 | Overflow enable |
| so_i | input | 1 | Current summary-overflow bit |
| tid_i | input | 2 | Transaction tag |
| valid_o | output | 1 | Result present |
| ready_i | input | 1 | Downstream accepts result |
| tid_o | output | 2 | Tag of the result |
| result_o | output | 64 | Product word |
| ov_o | output | 1 | Overflow |
| ov32_o | output | 1 | 32-bit overflow |
| ov_ok_o | output | 1 | Write qualifier for the overflow bits |
| so_o | output | 1 | New summary-overflow bit |
| so_ok_o | output | 1 | Write qualifier for summary overflow |
| cr_o | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_ok_o | output | 1 | Write qualifier for the condition field |

## Verification
Each of the six register forms is run against every pair drawn from sixteen corner operands, back to back:
- zero, one and two;
- all-ones and all-ones minus one;
- the largest positive and most negative 64-bit values;
- values whose upper word is non-zero and whose lower word sits at the 32-bit sign boundary.

These pairs separate signed from unsigned extension, show whether the upper operand word leaks into the 32-bit forms, and expose off-by-one errors in the overflow range tests. The immediate form pairs extreme 16-bit constants with junk in the upper B bits, which shows whether the constant is sign-extended and whether the upper bits are ignored. A further stream runs with downstream ready dropped in a fixed pattern; it tells a correct hold from lost, duplicated or reordered results, and a single operation on an idle pipe pins the latency.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [2:0] {
    MOP_LO32  = 3'd0,
    MOP_HI32S = 3'd1,
    MOP_HI32U = 3'd2,
    MOP_LO64  = 3'd3,
    MOP_HI64S = 3'd4,
    MOP_HI64U = 3'd5,
    MOP_IMM   = 3'd6,
    MOP_RSV   = 3'd7
  } mop_e;

  // Forms whose condition compare and formatting work on a 32-bit word
  function automatic logic is_word_op(mop_e op);
    return (op == MOP_LO32) || (op == MOP_HI32S) || (op == MOP_HI32U);
  endfunction

  // Forms that return an upper product half and never overflow
  function automatic logic is_high_op(mop_e op);
    return (op == MOP_HI32S) || (op == MOP_HI32U) ||
           (op == MOP_HI64S) || (op == MOP_HI64U);
  endfunction

endpackage

// File: rtl/mul_opnd_fmt.sv
module mul_opnd_fmt
  import mul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16
) (
  input  mop_e            op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN:0]   fa_o,
  output logic [XLEN:0]   fb_o
);
  localparam int HALF = XLEN / 2;
  localparam int EW   = XLEN + 1;

  logic [EW-1:0] a_w_s, b_w_s, a_w_u, b_w_u;
  logic [EW-1:0] a_d_s, b_d_s, a_d_u, b_d_u, b_imm;

  // Every extension variant is formed in parallel, then one pair is picked
  always_comb begin
    a_w_s = {{(EW-HALF){a_i[HALF-1]}}, a_i[HALF-1:0]};
    b_w_s = {{(EW-HALF){b_i[HALF-1]}}, b_i[HALF-1:0]};
    a_w_u = {{(EW-HALF){1'b0}}, a_i[HALF-1:0]};
    b_w_u = {{(EW-HALF){1'b0}}, b_i[HALF-1:0]};
    a_d_s = {a_i[XLEN-1], a_i};
    b_d_s = {b_i[XLEN-1], b_i};
    a_d_u = {1'b0, a_i};
    b_d_u = {1'b0, b_i};
    b_imm = {{(EW-IMMW){b_i[IMMW-1]}}, b_i[IMMW-1:0]};
  end

  always_comb begin
    case (op_i)
      MOP_LO32, MOP_HI32S: begin fa_o = a_w_s; fb_o = b_w_s; end
      MOP_HI32U:           begin fa_o = a_w_u; fb_o = b_w_u; end
      MOP_HI64U:           begin fa_o = a_d_u; fb_o = b_d_u; end
      MOP_IMM:             begin fa_o = a_d_s; fb_o = b_imm; end
      default:             begin fa_o = a_d_s; fb_o = b_d_s; end
    endcase
  end

endmodule

// File: rtl/mul_core.sv
module mul_core #(
  parameter int XLEN = 64
) (
  input  logic [XLEN:0]     fa_i,
  input  logic [XLEN:0]     fb_i,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int PW = 2 * XLEN;

  logic signed [PW-1:0] ea, eb;

  // Sign-extend the formatted operands to product width; the low PW
  // bits of the product are exact for both signed and zero-extended inputs
  always_comb begin
    ea     = PW'($signed(fa_i));
    eb     = PW'($signed(fb_i));
    prod_o = ea * eb;
  end

endmodule

// File: rtl/mul_result_fmt.sv
module mul_result_fmt
  import mul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  mop_e              op_i,
  input  logic [2*XLEN-1:0] prod_i,
  input  logic              oe_i,
  input  logic              so_i,
  output logic [XLEN-1:0]   res_o,
  output logic              ov_o,
  output logic              so_o,
  output logic [3:0]        cr_o
);
  localparam int HALF = XLEN / 2;
  localparam int PW   = 2 * XLEN;

  logic ov_word, ov_dbl;
  logic lt, eq;

  always_comb begin
    // The product fits the signed range only if its top bits match the sign
    ov_word = !((&prod_i[XLEN-1:HALF-1]) || !(|prod_i[XLEN-1:HALF-1]));
    ov_dbl  = !((&prod_i[PW-1:XLEN-1])   || !(|prod_i[PW-1:XLEN-1]));

    case (op_i)
      MOP_LO32:             begin res_o = prod_i[XLEN-1:0];                ov_o = ov_word; end
      MOP_HI32S, MOP_HI32U: begin res_o = {2{prod_i[XLEN-1:HALF]}};       ov_o = 1'b0;    end
      MOP_HI64S, MOP_HI64U: begin res_o = prod_i[PW-1:XLEN];              ov_o = 1'b0;    end
      default:              begin res_o = prod_i[XLEN-1:0];                ov_o = ov_dbl;  end
    endcase

    so_o = so_i | (oe_i & ov_o);

    if (is_word_op(op_i)) begin
      lt = res_o[HALF-1];
      eq = (res_o[HALF-1:0] == '0);
    end else begin
      lt = res_o[XLEN-1];
      eq = (res_o == '0);
    end
    cr_o = {lt, !lt && !eq, eq, so_o};
  end

endmodule

// File: rtl/mul_pipe_unit.sv
module mul_pipe_unit
  import mul_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter int TIDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  output logic            ready_o,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            rc_i,
  input  logic            oe_i,
  input  logic            so_i,
  input  logic [TIDW-1:0] tid_i,
  output logic            valid_o,
  input  logic            ready_i,
  output logic [TIDW-1:0] tid_o,
  output logic [XLEN-1:0] result_o,
  output logic            ov_o,
  output logic            ov32_o,
  output logic            ov_ok_o,
  output logic            so_o,
  output logic            so_ok_o,
  output logic [3:0]      cr_o,
  output logic            cr_ok_o
);
  localparam int EW   = XLEN + 1;
  localparam int PW   = 2 * XLEN;
  localparam int HALF = XLEN / 2;

  typedef struct packed {
    logic [TIDW-1:0] tid;
    mop_e            op;
    logic            rc;
    logic            oe;
    logic            so;
  } ctl_t;

  typedef struct packed {
    ctl_t          c;
    logic [EW-1:0] fa;
    logic [EW-1:0] fb;
  } st1_t;

  typedef struct packed {
    ctl_t          c;
    logic [PW-1:0] prod;
  } st2_t;

  typedef struct packed {
    ctl_t            c;
    logic [XLEN-1:0] res;
    logic            ov;
    logic            so_new;
    logic [3:0]      cr;
  } st3_t;

  logic v1_q, v2_q, v3_q;
  st1_t d1_q, d1_n;
  st2_t d2_q, d2_n;
  st3_t d3_q, d3_n;
  logic adv;

  logic [EW-1:0]   fa, fb;
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] fmt_res;
  logic            fmt_ov, fmt_so;
  logic [3:0]      fmt_cr;

  // Whole pipe advances unless a finished result is blocked
  assign adv     = !v3_q || ready_i;
  assign ready_o = adv;

  mul_opnd_fmt #(.XLEN(XLEN), .IMMW(IMMW)) u_opnd (
    .op_i (mop_e'(op_i)),
    .a_i  (a_i),
    .b_i  (b_i),
    .fa_o (fa),
    .fb_o (fb)
  );

  mul_core #(.XLEN(XLEN)) u_core (
    .fa_i   (d1_q.fa),
    .fb_i   (d1_q.fb),
    .prod_o (prod)
  );

  mul_result_fmt #(.XLEN(XLEN)) u_rfmt (
    .op_i   (d2_q.c.op),
    .prod_i (d2_q.prod),
    .oe_i   (d2_q.c.oe),
    .so_i   (d2_q.c.so),
    .res_o  (fmt_res),
    .ov_o   (fmt_ov),
    .so_o   (fmt_so),
    .cr_o   (fmt_cr)
  );

  // Next-state assembly
  always_comb begin
    d1_n.c.tid = tid_i;
    d1_n.c.op  = mop_e'(op_i);
    d1_n.c.rc  = rc_i;
    d1_n.c.oe  = oe_i;
    d1_n.c.so  = so_i;
    d1_n.fa    = fa;
    d1_n.fb    = fb;

    d2_n.c     = d1_q.c;
    d2_n.prod  = prod;

    d3_n.c      = d2_q.c;
    d3_n.res    = fmt_res;
    d3_n.ov     = fmt_ov;
    d3_n.so_new = fmt_so;
    d3_n.cr     = fmt_cr;
  end

  // Valid chain with asynchronous reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else if (adv) begin
      v1_q <= valid_i;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  // Data registers: no reset, loaded only when a valid item moves in
  always_ff @(posedge clk) begin
    if (adv && valid_i) d1_q <= d1_n;
    if (adv && v1_q)    d2_q <= d2_n;
    if (adv && v2_q)    d3_q <= d3_n;
  end

  assign valid_o  = v3_q;
  assign tid_o    = d3_q.c.tid;
  assign result_o = d3_q.res;
  assign ov_o     = d3_q.ov;
  assign ov32_o   = d3_q.ov;
  assign ov_ok_o  = d3_q.c.oe;
  assign so_o     = d3_q.so_new;
  assign so_ok_o  = d3_q.c.oe;
  assign cr_o     = d3_q.cr;
  assign cr_ok_o  = d3_q.c.rc;

  // Cycles since reset, for properties that look back three cycles
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3 && $past(valid_i, 3) && $past(ready_i, 3) &&
     $past(ready_i, 2) && $past(ready_i)) |-> valid_o); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(result_o) && $stable(tid_o))); // R10

  AST_HIGH_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && is_high_op(d3_q.c.op)) |-> !ov_o); // R4

  AST_HALF_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (d3_q.c.op == MOP_HI32S || d3_q.c.op == MOP_HI32U)) |->
    (result_o[XLEN-1:HALF] == result_o[HALF-1:0])); // R2

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && d3_q.c.so) |-> so_o); // R7

  AST_CR_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cr_ok_o) |-> ($onehot(cr_o[3:1]) && cr_o[0] == so_o)); // R8

endmodule

// File: tb/sim_mul_pipe_unit.sv
`timescale 1ns/1ps
module sim_mul_pipe_unit;

  logic        clk;
  logic        rst_n;
  logic        valid_i, ready_o, ready_i, valid_o;
  logic [2:0]  op_i;
  logic [63:0] a_i, b_i, result_o;
  logic        rc_i, oe_i, so_i;
  logic [1:0]  tid_i, tid_o;
  logic        ov_o, ov32_o, ov_ok_o, so_o, so_ok_o, cr_ok_o;
  logic [3:0]  cr_o;

  mul_pipe_unit u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .ready_o(ready_o),
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .rc_i(rc_i), .oe_i(oe_i), .so_i(so_i),
    .tid_i(tid_i), .valid_o(valid_o), .ready_i(ready_i), .tid_o(tid_o),
    .result_o(result_o), .ov_o(ov_o), .ov32_o(ov32_o), .ov_ok_o(ov_ok_o),
    .so_o(so_o), .so_ok_o(so_ok_o), .cr_o(cr_o), .cr_ok_o(cr_ok_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  tid;
    logic [2:0]  op;
    logic [63:0] res;
    logic        ov;
    logic        oe;
    logic        so;
    logic        rc;
    logic [3:0]  cr;
  } exp_t;

  exp_t q [0:4095];
  int wr = 0, rd = 0, nchk = 0, nfail = 0, cyc = 0;
  logic        hold_prev = 1'b0;
  logic [63:0] held_res;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0:       return "R1";
      3'd1, 3'd2: return "R2";
      3'd3:       return "R3";
      3'd4, 3'd5: return "R4";
      default:    return "R5";
    endcase
  endfunction

  // Arithmetic model written from the requirements
  function automatic exp_t ref_calc(input logic [2:0] op, input logic [63:0] a,
                                    input logic [63:0] b, input logic rc,
                                    input logic oe, input logic so);
    exp_t e;
    logic signed [127:0] x, sa, sb;
    logic [127:0] ux;
    logic signed [63:0] v;
    e = '0;
    e.op = op; e.oe = oe; e.rc = rc;
    case (op)
      3'd0, 3'd1: begin
        sa = $signed({{96{a[31]}}, a[31:0]});
        sb = $signed({{96{b[31]}}, b[31:0]});
        x  = sa * sb;
        if (op == 3'd0) begin
          e.res = x[63:0];
          e.ov  = (x > 128'sd2147483647) || (x < -128'sd2147483648);
        end else e.res = {x[63:32], x[63:32]};
      end
      3'd2: begin
        ux = {96'd0, a[31:0]} * {96'd0, b[31:0]};
        e.res = {ux[63:32], ux[63:32]};
      end
      3'd5: begin
        ux = {64'd0, a} * {64'd0, b};
        e.res = ux[127:64];
      end
      default: begin
        sa = $signed({{64{a[63]}}, a});
        if (op == 3'd6) sb = $signed({{112{b[15]}}, b[15:0]});
        else            sb = $signed({{64{b[63]}}, b});
        x = sa * sb;
        if (op == 3'd4) e.res = x[127:64];
        else begin
          e.res = x[63:0];
          e.ov  = (x > 128'sh7FFF_FFFF_FFFF_FFFF) ||
                  (x < -128'sh8000_0000_0000_0000);
        end
      end
    endcase
    e.so = so | (oe & e.ov);
    if (op <= 3'd2) v = $signed({{32{e.res[31]}}, e.res[31:0]});
    else            v = $signed(e.res);
    e.cr = {v < 0, v > 0, v == 0, e.so};
    return e;
  endfunction

  function automatic logic [63:0] corner(input int i);
    case (i)
      0:  return 64'h0;
      1:  return 64'h1;
      2:  return 64'h2;
      3:  return 64'hFFFF_FFFF_FFFF_FFFF;
      4:  return 64'hFFFF_FFFF_FFFF_FFFE;
      5:  return 64'h7FFF_FFFF_FFFF_FFFF;
      6:  return 64'h8000_0000_0000_0000;
      7:  return 64'h1234_5678_0000_0000;
      8:  return 64'h1234_5678_8000_0000;
      9:  return 64'h1234_5678_FFFF_FFFF;
      10: return 64'h1234_5678_7FFF_FFFF;
      11: return 64'h0000_0000_FFFF_FFFF;
      12: return 64'h0000_0000_7FFF_FFFF;
      13: return 64'h0000_0000_8000_0000;
      14: return 64'h0000_0000_FFFF_FFFE;
      default: return 64'h0000_0000_FFFF_FFFD;
    endcase
  endfunction

  function automatic logic [15:0] imm_val(input int i);
    case (i)
      0: return 16'h8000;  1: return 16'h8001;  2: return 16'h8002;
      3: return 16'hFFFE;  4: return 16'hFFFF;  5: return 16'h0000;
      6: return 16'h0001;  7: return 16'h0002;  8: return 16'h7FFE;
      9: return 16'h7FFF;  10: return 16'h1234; 11: return 16'hC3A5;
      12: return 16'h00FF; 13: return 16'hFF00; 14: return 16'h5A5A;
      default: return 16'hA5A5;
    endcase
  endfunction

  task automatic issue(input logic [2:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic rc, input logic oe,
                       input logic so, input bit stall);
    logic acc;
    exp_t e;
    op_i = op; a_i = a; b_i = b; rc_i = rc; oe_i = oe; so_i = so;
    tid_i = wr[1:0]; valid_i = 1'b1;
    do begin
      ready_i = stall ? ((cyc % 3) != 1) : 1'b1;
      cyc++;
      #1;
      acc = ready_o;
      @(negedge clk);
    end while (!acc);
    e = ref_calc(op, a, b, rc, oe, so);
    e.tid = wr[1:0];
    q[wr] = e;
    wr++;
  endtask

  // Output monitor, sampled well away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        chk("R10", "ready_o", {63'd0, ready_o}, {63'd0, (!valid_o) | ready_i});
        if (hold_prev) begin
          chk("R10", "held valid", {63'd0, valid_o}, 64'd1);
          chk("R10", "held result", result_o, held_res);
        end
        hold_prev = valid_o && !ready_i;
        held_res  = result_o;
        if (valid_o && ready_i) begin
          if (rd >= wr) begin
            chk("R9", "unexpected result", 64'd1, 64'd0);
          end else begin
            exp_t e;
            e = q[rd];
            rd++;
            chk(op_tag(e.op), "result", result_o, e.res);
            chk(op_tag(e.op), "ov", {63'd0, ov_o}, {63'd0, e.ov});
            chk(op_tag(e.op), "ov32", {63'd0, ov32_o}, {63'd0, e.ov});
            chk("R6", "ov_ok", {63'd0, ov_ok_o}, {63'd0, e.oe});
            chk("R6", "so_ok", {63'd0, so_ok_o}, {63'd0, e.oe});
            chk("R7", "so", {63'd0, so_o}, {63'd0, e.so});
            chk("R8", "cr_ok", {63'd0, cr_ok_o}, {63'd0, e.rc});
            if (e.rc) chk("R8", "cr", {60'd0, cr_o}, {60'd0, e.cr});
            chk("R9", "tid", {62'd0, tid_o}, {62'd0, e.tid});
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", rd, wr);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; valid_i = 1'b0; ready_i = 1'b1;
    op_i = '0; a_i = '0; b_i = '0; rc_i = 1'b0; oe_i = 1'b0; so_i = 1'b0; tid_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "reset valid_o", {63'd0, valid_o}, 64'd0);
    chk("R9", "reset ready_o", {63'd0, ready_o}, 64'd1);

    // R9: single operation on an idle pipe
    issue(3'd3, 64'd7, 64'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    valid_i = 1'b0;
    n = 1;
    while (!valid_o && n < 10) begin
      @(negedge clk);
      n++;
    end
    chk("R9", "latency", n, 64'd3);
    repeat (4) @(negedge clk);

    // R1..R4: register forms over all corner pairs, back to back
    for (int op = 0; op < 6; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          issue(op[2:0], corner(i), corner(j), i[0] ^ j[1],
                i[1] ^ j[0], (i + j + op) % 5 == 0, 1'b0);

    // R5: immediate form with junk in the upper B bits
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        issue(3'd6, corner(i), {48'hDEAD_BEEF_0F0F, imm_val(j)},
              j[0], i[0], j[2], 1'b0);

    // R10: stream with downstream stalls
    for (int k = 0; k < 70; k++)
      issue(k % 7 == 6 ? 3'd6 : 3'(k % 6), corner(k % 16), corner((k * 5) % 16),
            k[0], k[1], k[2], 1'b1);

    valid_i = 1'b0;
    ready_i = 1'b1;
    while (rd < wr) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule